// File: doc/BRIEF.md
# Vector Element Loop Sequencer

This block expands a single vector-style operation into a series of per-element micro-operations for an external ALU. When an operation arrives, the sequencer captures its settings: the programmed length, a length ceiling, a sub-vector count of one to four, an element width and a vector/scalar flag for each operand. It then walks an element counter and, inside it, a sub-vector counter. For every step it presents one register number and one byte offset per operand, together with the element-width tag. The ALU accepts each step through a valid/ready handshake.

Narrow elements are packed densely into 64-bit registers. A vector operand therefore moves to the next register only after it has filled the current one. A scalar operand stays on its base register and lane. When every operand is scalar, the block runs with a length of one, so a scalar access to any register from 0 to 127 leaves the stored length alone. A zero length with any vector operand ends the operation as a no-op. An address that would go beyond register 127 ends the sequence with an error.

Top module: `elem_loop_seq`

## Requirements
- R1: A `start` pulse is taken only while the block is idle (not busy and not signalling done). `busy` rises in the cycle after an accepted start and stays high until the cycle after the final handshake. A `start` that arrives while busy or during the done cycle has no effect.
- R2: The counters advance only in a cycle where `uop_valid` and `uop_ready` are both high. While `uop_valid` is high and `uop_ready` is low, every micro-operation output holds its value.
- R3: If at least one operand is vector, the effective length is the smaller of `vl` and `maxvl`. The number of handshakes equals the effective length times the sub-vector count, which is `svl_m1 + 1`.
- R4: If no operand is vector (`vec_sel` is all zeros), the effective length is one whatever `vl` holds, including zero, so exactly `svl_m1 + 1` micro-operations are issued.
- R5: An effective length of zero issues no micro-operation. `done` and `nop` are then both high in the cycle after the start.
- R6: The sub-vector index `uop_sub` is the inner loop and counts from 0 to `svl_m1`. The element index `uop_elem` advances by one each time `uop_sub` wraps.
- R7: The element-width code on `ew` is 0 for 64 bits, 1 for 32, 2 for 16 and 3 for 8. `uop_ew` repeats the code that was captured at start.
- R8: For a vector operand, let idx = elem*(svl_m1+1)+sub and let B = idx times the element size in bytes. The register is then base + B/8, and the lane is B mod 8. Every lane is aligned to the element size.
- R9: A scalar operand always reports its base register and lane 0. Any base from 0 to 127 can be reached.
- R10: `uop_last` is high only on the final micro-operation of the sequence.
- R11: `done` is a one-cycle pulse in the cycle after the final handshake. `busy` and `uop_valid` are low while `done` is high.
- R12: A micro-operation whose vector address would exceed 127 is never issued. Instead, `done` and `err` are pulsed together in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a new operation |
| vl | input | LEN_W | Programmed vector length |
| maxvl | input | LEN_W | Length ceiling |
| svl_m1 | input | 2 | Sub-vector count minus one |
| ew | input | 2 | Element-width code |
| vec_sel | input | NOPS | Per-operand vector flag (1 = vector) |
| base_regs | input | NOPS*7 | Per-operand base register, operand 0 in the low bits |
| busy | output | 1 | Sequence in progress |
| uop_valid | output | 1 | Micro-operation offered |
| uop_ready | input | 1 | ALU accepts the micro-operation |
| uop_regs | output | NOPS*7 | Per-operand register number |
| uop_lanes | output | NOPS*3 | Per-operand byte offset within the register |
| uop_ew | output | 2 | Element-width tag |
| uop_elem | output | LEN_W | Element index |
| uop_sub | output | 2 | Sub-vector index |
| uop_last | output | 1 | Final micro-operation |
| done | output | 1 | One-cycle end-of-operation pulse |
| nop | output | 1 | Operation ended as a no-op (with done) |
| err | output | 1 | Operation ended on address overflow (with done) |

## Verification
The collision of interest is a new `start` request that arrives in the same cycle as the final handshake, or in the done cycle that follows it. One test holds `start` high for the whole operation, including both of those cycles, while `uop_ready` stalls on a repeating pattern. The cycle-level reference model in the bench must then see `busy` fall, `done` pulse once, and the block stay idle without taking a second operation. A second overlap is an address overflow that meets a stalled handshake. Here the model requires that the out-of-range step is never offered and that `err` appears together with `done`.

// File: rtl/esq_pkg.sv
package esq_pkg;
  localparam int REG_W  = 7;
  localparam int LANE_W = 3;

  typedef enum logic [1:0] {
    EW_D64 = 2'd0,
    EW_D32 = 2'd1,
    EW_D16 = 2'd2,
    EW_D8  = 2'd3
  } ew_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } st_e;

  // log2 of the element size in bytes
  function automatic logic [1:0] ew_shift(ew_e w);
    return 2'd3 - w;
  endfunction

  // low lane bits that must be zero for an aligned element
  function automatic logic [LANE_W-1:0] lane_mask(ew_e w);
    return LANE_W'((4'd1 << ew_shift(w)) - 4'd1);
  endfunction
endpackage

// File: rtl/esq_rst_sync.sv
module esq_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_o = sync_q;
endmodule

// File: rtl/esq_lane_addr.sv
module esq_lane_addr
  import esq_pkg::*;
#(
  parameter int IDX_W = 9
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  ew_e               ew_i,
  input  logic              is_vec_i,
  input  logic [REG_W-1:0]  base_i,
  output logic [REG_W-1:0]  reg_o,
  output logic [LANE_W-1:0] lane_o,
  output logic              ovf_o
);
  localparam int BT_W    = IDX_W + LANE_W;
  localparam int SUM_W   = ((IDX_W > REG_W) ? IDX_W : REG_W) + 1;
  localparam int MAX_REG = (1 << REG_W) - 1;

  logic [BT_W-1:0]  byte_off;
  logic [SUM_W-1:0] reg_sum;

  always_comb begin
    byte_off = {{LANE_W{1'b0}}, idx_i} << ew_shift(ew_i);
    reg_sum  = SUM_W'(base_i) + SUM_W'(byte_off[BT_W-1:LANE_W]);
    reg_o    = is_vec_i ? reg_sum[REG_W-1:0] : base_i;
    lane_o   = is_vec_i ? byte_off[LANE_W-1:0] : '0;
    ovf_o    = is_vec_i && (reg_sum > SUM_W'(MAX_REG));
  end
endmodule

// File: rtl/esq_ctrl.sv
module esq_ctrl
  import esq_pkg::*;
#(
  parameter  int LEN_W = 7,
  localparam int IDX_W = LEN_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [IDX_W-1:0] total_i,
  input  logic [1:0]       svl_m1_i,
  input  logic             ovf_i,
  input  logic             ready_i,
  output logic             accept_o,
  output logic             valid_o,
  output logic             busy_o,
  output logic             last_o,
  output logic             done_o,
  output logic             nop_o,
  output logic             err_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [LEN_W-1:0] elem_o,
  output logic [1:0]       sub_o
);
  st_e              state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d, total_q;
  logic [LEN_W-1:0] elem_q, elem_d;
  logic [1:0]       sub_q, sub_d, svl_m1_q;
  logic             nop_q, nop_d, err_q, err_d;
  logic             fire, cnt_en;

  assign accept_o = start_i && (state_q == ST_IDLE);
  assign valid_o  = (state_q == ST_RUN) && !ovf_i;
  assign busy_o   = (state_q == ST_RUN);
  assign last_o   = busy_o && (idx_q == (total_q - IDX_W'(1)));
  assign done_o   = (state_q == ST_DONE);
  assign nop_o    = done_o && nop_q;
  assign err_o    = done_o && err_q;
  assign idx_o    = idx_q;
  assign elem_o   = elem_q;
  assign sub_o    = sub_q;
  assign fire     = valid_o && ready_i;
  assign cnt_en   = accept_o || (fire && !last_o);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    elem_d  = elem_q;
    sub_d   = sub_q;
    nop_d   = nop_q;
    err_d   = err_q;
    case (state_q)
      ST_IDLE: begin
        if (accept_o) begin
          idx_d   = '0;
          elem_d  = '0;
          sub_d   = '0;
          err_d   = 1'b0;
          nop_d   = (total_i == '0);
          state_d = (total_i == '0) ? ST_DONE : ST_RUN;
        end
      end
      ST_RUN: begin
        if (ovf_i) begin
          err_d   = 1'b1;
          state_d = ST_DONE;
        end else if (fire) begin
          if (last_o) begin
            state_d = ST_DONE;
          end else begin
            idx_d = idx_q + IDX_W'(1);
            if (sub_q == svl_m1_q) begin
              sub_d  = '0;
              elem_d = elem_q + LEN_W'(1);
            end else begin
              sub_d = sub_q + 2'd1;
            end
          end
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      elem_q   <= '0;
      sub_q    <= '0;
      total_q  <= '0;
      svl_m1_q <= '0;
      nop_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      nop_q   <= nop_d;
      err_q   <= err_d;
      if (accept_o) begin
        total_q  <= total_i;
        svl_m1_q <= svl_m1_i;
      end
      if (cnt_en) begin
        idx_q  <= idx_d;
        elem_q <= elem_d;
        sub_q  <= sub_d;
      end
    end
  end
endmodule

// File: rtl/elem_loop_seq.sv
module elem_loop_seq
  import esq_pkg::*;
#(
  parameter  int NOPS  = 3,
  parameter  int LEN_W = 7,
  localparam int IDX_W = LEN_W + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [LEN_W-1:0]        vl,
  input  logic [LEN_W-1:0]        maxvl,
  input  logic [1:0]              svl_m1,
  input  logic [1:0]              ew,
  input  logic [NOPS-1:0]         vec_sel,
  input  logic [NOPS*REG_W-1:0]   base_regs,
  output logic                    busy,
  output logic                    uop_valid,
  input  logic                    uop_ready,
  output logic [NOPS*REG_W-1:0]   uop_regs,
  output logic [NOPS*LANE_W-1:0]  uop_lanes,
  output logic [1:0]              uop_ew,
  output logic [LEN_W-1:0]        uop_elem,
  output logic [1:0]              uop_sub,
  output logic                    uop_last,
  output logic                    done,
  output logic                    nop,
  output logic                    err
);
  logic                  rst_sync_n;
  logic                  accept;
  logic [LEN_W-1:0]      len_clamp, len_eff;
  logic [2:0]            svl_cnt;
  logic [IDX_W-1:0]      total, idx;
  ew_e                   ew_q;
  logic [NOPS-1:0]       vec_q, ovf_vec;
  logic [NOPS*REG_W-1:0] base_q;

  esq_rst_sync u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  // effective length: all-scalar forces one, otherwise clamp to ceiling
  always_comb begin
    len_clamp = (vl > maxvl) ? maxvl : vl;
    len_eff   = (|vec_sel) ? len_clamp : LEN_W'(1);
    svl_cnt   = {1'b0, svl_m1} + 3'd1;
    total     = IDX_W'(len_eff) * IDX_W'(svl_cnt);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ew_q   <= EW_D64;
      vec_q  <= '0;
      base_q <= '0;
    end else if (accept) begin
      ew_q   <= ew_e'(ew);
      vec_q  <= vec_sel;
      base_q <= base_regs;
    end
  end

  esq_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start_i  (start),
    .total_i  (total),
    .svl_m1_i (svl_m1),
    .ovf_i    (|ovf_vec),
    .ready_i  (uop_ready),
    .accept_o (accept),
    .valid_o  (uop_valid),
    .busy_o   (busy),
    .last_o   (uop_last),
    .done_o   (done),
    .nop_o    (nop),
    .err_o    (err),
    .idx_o    (idx),
    .elem_o   (uop_elem),
    .sub_o    (uop_sub)
  );

  for (genvar i = 0; i < NOPS; i++) begin : g_opnd
    esq_lane_addr #(.IDX_W(IDX_W)) u_addr (
      .idx_i    (idx),
      .ew_i     (ew_q),
      .is_vec_i (vec_q[i]),
      .base_i   (base_q[i*REG_W +: REG_W]),
      .reg_o    (uop_regs[i*REG_W +: REG_W]),
      .lane_o   (uop_lanes[i*LANE_W +: LANE_W]),
      .ovf_o    (ovf_vec[i])
    );
  end

  assign uop_ew = ew_q;
endmodule

// File: rtl/esq_checker.sv
module esq_checker
  import esq_pkg::*;
#(
  parameter int NOPS = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start,
  input logic                   busy,
  input logic                   uop_valid,
  input logic                   uop_ready,
  input logic [NOPS*REG_W-1:0]  uop_regs,
  input logic [NOPS*LANE_W-1:0] uop_lanes,
  input logic [1:0]             uop_ew,
  input logic                   uop_last,
  input logic                   done,
  input logic                   nop,
  input logic                   err
);
  AST_VALID_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid |-> busy) else $error("valid outside busy"); // R2

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && !uop_ready) |=> (uop_valid && $stable(uop_regs) && $stable(uop_lanes) && $stable(uop_last)))
    else $error("outputs moved during stall"); // R2

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start)) else $error("busy without start"); // R1

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than one cycle"); // R11

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !uop_valid)) else $error("activity during done"); // R11

  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && uop_ready && uop_last) |=> done) else $error("no done after last"); // R11

  AST_NOP_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    nop |-> done) else $error("nop without done"); // R5

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (done && !uop_valid)) else $error("err without done"); // R12

  for (genvar i = 0; i < NOPS; i++) begin : g_align
    AST_LANE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      uop_valid |-> ((uop_lanes[i*LANE_W +: LANE_W] & lane_mask(ew_e'(uop_ew))) == '0))
      else $error("misaligned lane"); // R8
  end
endmodule

bind elem_loop_seq esq_checker #(.NOPS(NOPS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .uop_valid (uop_valid),
  .uop_ready (uop_ready),
  .uop_regs  (uop_regs),
  .uop_lanes (uop_lanes),
  .uop_ew    (uop_ew),
  .uop_last  (uop_last),
  .done      (done),
  .nop       (nop),
  .err       (err)
);

// File: tb/elem_loop_seq_tb.sv
module elem_loop_seq_tb;
  localparam int NOPS  = 3;
  localparam int LEN_W = 7;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [LEN_W-1:0]  vl = '0, maxvl = '0;
  logic [1:0]        svl_m1 = '0, ew = '0;
  logic [NOPS-1:0]   vec_sel = '0;
  logic [NOPS*7-1:0] base_regs = '0;
  logic              uop_ready = 1'b0;
  logic              busy, uop_valid, uop_last, done, nop, err;
  logic [NOPS*7-1:0] uop_regs;
  logic [NOPS*3-1:0] uop_lanes;
  logic [1:0]        uop_ew, uop_sub;
  logic [LEN_W-1:0]  uop_elem;

  int n_checks = 0, n_fail = 0, fires = 0, cyc = 0, ready_mode = 0;
  bit wd_hit = 0;

  // reference model state
  int m_state = 0, m_k = 0, m_total = 0, m_svl = 1, m_bytes = 8, m_ew = 0;
  int m_base[NOPS];
  bit m_vec[NOPS];
  bit m_nop = 0, m_err = 0;

  always #2 clk = ~clk;

  elem_loop_seq #(.NOPS(NOPS), .LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .maxvl(maxvl),
    .svl_m1(svl_m1), .ew(ew), .vec_sel(vec_sel), .base_regs(base_regs),
    .busy(busy), .uop_valid(uop_valid), .uop_ready(uop_ready),
    .uop_regs(uop_regs), .uop_lanes(uop_lanes), .uop_ew(uop_ew),
    .uop_elem(uop_elem), .uop_sub(uop_sub), .uop_last(uop_last),
    .done(done), .nop(nop), .err(err)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  function automatic int m_reg(input int i);
    if (!m_vec[i]) return m_base[i];
    return m_base[i] + (m_k * m_bytes) / 8;
  endfunction

  function automatic int m_lane(input int i);
    if (!m_vec[i]) return 0;
    return (m_k * m_bytes) % 8;
  endfunction

  function automatic bit m_ovf();
    for (int i = 0; i < NOPS; i++)
      if (m_reg(i) > 127) return 1'b1;
    return 1'b0;
  endfunction

  // model update at the active edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_nop = 0; m_err = 0; m_k = 0;
    end else begin
      if (uop_valid && uop_ready) fires++;
      case (m_state)
        0: if (start) begin
          int len;
          m_svl = svl_m1 + 1;
          m_ew = ew;
          m_bytes = 8 >> ew;
          for (int i = 0; i < NOPS; i++) begin
            m_vec[i] = vec_sel[i];
            m_base[i] = base_regs[i*7 +: 7];
          end
          if (vec_sel == 0) len = 1;
          else len = (vl > maxvl) ? maxvl : vl;
          m_total = len * m_svl;
          m_k = 0; m_err = 0;
          m_nop = (m_total == 0);
          m_state = m_nop ? 2 : 1;
        end
        1: begin
          if (m_ovf()) begin
            m_err = 1; m_state = 2;
          end else if (uop_ready) begin
            if (m_k == m_total - 1) m_state = 2;
            else m_k++;
          end
        end
        default: m_state = 0;
      endcase
    end
  end

  // compare away from the active edge, then drive ready
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !wd_hit) begin
      bit ev;
      ev = (m_state == 1) && !m_ovf();
      chk("R1", "busy", busy, m_state == 1);
      chk("R2", "uop_valid", uop_valid, ev);
      chk("R11", "done", done, m_state == 2);
      chk("R5", "nop", nop, (m_state == 2) && m_nop);
      chk("R12", "err", err, (m_state == 2) && m_err);
      if (ev) begin
        for (int i = 0; i < NOPS; i++) begin
          chk(m_vec[i] ? "R8" : "R9", "reg", uop_regs[i*7 +: 7], m_reg(i));
          chk(m_vec[i] ? "R8" : "R9", "lane", uop_lanes[i*3 +: 3], m_lane(i));
        end
        chk("R6", "elem", uop_elem, m_k / m_svl);
        chk("R6", "sub", uop_sub, m_k % m_svl);
        chk("R10", "last", uop_last, m_k == m_total - 1);
        chk("R7", "ew", uop_ew, m_ew);
      end
    end
    uop_ready = (ready_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
  end

  task automatic run_op(input int l, input int lmax, input int sm1, input int w, input int vs,
                        input int b0, input int b1, input int b2, input int exp_n,
                        input string req, input bit hold);
    int f0, guard;
    @(negedge clk);
    vl = l[LEN_W-1:0]; maxvl = lmax[LEN_W-1:0]; svl_m1 = sm1[1:0]; ew = w[1:0];
    vec_sel = vs[NOPS-1:0];
    base_regs = {b2[6:0], b1[6:0], b0[6:0]};
    f0 = fires;
    start = 1'b1;
    @(negedge clk);
    if (!hold) begin
      start = 1'b0;
      vl = 7'd33; svl_m1 = 2'd0; vec_sel = '1; // changes after start have no effect (R1)
    end
    guard = 0;
    while (!done && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    chk(req, "handshake count", fires - f0, exp_n);
    @(negedge clk);
    start = 1'b0;
    chk("R1", "idle after done", busy, 0);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    wd_hit = 1;
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "reset busy", busy, 0);
    chk("R2", "reset valid", uop_valid, 0);
    chk("R11", "reset done", done, 0);
    // R3: plain length below ceiling, 64-bit elements
    run_op(5, 8, 0, 0, 7, 10, 20, 30, 5, "R3", 0);
    // R3: length clamped to ceiling, 8-bit elements, three-wide sub-vectors
    ready_mode = 1;
    run_op(10, 6, 2, 3, 7, 0, 40, 80, 18, "R3", 0);
    // R5: zero length with a vector operand
    run_op(0, 8, 1, 0, 1, 5, 6, 7, 0, "R5", 0);
    // R4, R9: all scalar with zero length, high registers
    run_op(0, 0, 3, 2, 0, 32, 100, 127, 4, "R4", 0);
    run_op(9, 9, 0, 0, 0, 1, 2, 3, 1, "R4", 0);
    // R12: vector walk past register 127 under stalls
    run_op(12, 20, 0, 0, 1, 120, 0, 0, 8, "R12", 0);
    // R6, R1: 16-bit pairs, start held through last handshake and done cycle
    run_op(4, 4, 1, 2, 3, 8, 16, 60, 8, "R6", 1);
    // R8: 32-bit triples
    ready_mode = 0;
    run_op(7, 7, 2, 1, 7, 0, 50, 90, 21, "R8", 0);
    // R8: full length, 8-bit quads ending exactly on register 127
    run_op(127, 127, 3, 3, 4, 0, 0, 64, 508, "R8", 0);
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule